// File: doc/BRIEF.md
# S/PDIF Biphase-Mark Subframe Transmitter

This block turns a stream of stereo audio samples into a single-wire S/PDIF line. Each sample pair comes in over a valid/ready handshake as two 24-bit words. The low nibble of each word is the auxiliary field and the upper 20 bits are the audio word. A validity flag travels with each pair. The block builds a 32-slot subframe for each channel and encodes it as biphase mark. A sync preamble opens every subframe. The auxiliary and audio bits follow, and then the validity, user, channel-status and parity bits.

A frame counter runs through the 192-frame block. It picks the block-start preamble for the left subframe of frame 0. It also picks the channel-status bit for each frame from a 40-bit consumer channel-status word. That word is captured once at the start of every block. The line advances by one half bit cell on each pulse of a clock enable, so the bit rate is set by whatever produces that pulse.

When the enable input is low, the line is held low and all position counters return to the block start. If no sample is waiting when a frame begins, the block sends a frame of zero audio marked invalid.

Top module: `spdif_bmc_tx`

## Requirements
- R1: In each subframe, slots 0–3 are the preamble. Slots 4–27 carry the 24-bit channel word least significant bit first: word bit 0 is in slot 4 and word bit 23 is in slot 27. The left word goes in the first subframe of a frame and the right word in the second.
- R2: Slot 28 carries the validity flag that arrived with the sample pair (1 = invalid), in both subframes. Slot 29, the user bit, is always 0.
- R3: Slot 31 is a parity bit chosen so that slots 4–31 together hold an even number of ones.
- R4: Every slot from 4 to 31 is biphase-mark coded. The line changes level at the start of every bit cell, and changes again at mid-cell only when the bit is 1. One half-cell level is emitted per `cell_tick` pulse, so a bit cell takes two pulses.
- R5: Each preamble lasts eight half-cells, sent as levels starting from the most significant bit of its pattern. The patterns are 8'hE8 for the left subframe of frame 0, 8'hE2 for the left subframe of every other frame, and 8'hE4 for every right subframe. The pattern is inverted when the line was high just before the preamble.
- R6: A block is 192 frames, numbered 0–191, after which the count wraps to 0. Both subframes of frame f < 40 carry channel-status bit `chan_status[f]` in slot 30. Frames 40–191 carry 0 there.
- R7: `chan_status` is captured when frame 0 begins. A change made during a block first appears in the following block.
- R8: `smp_ready` is high exactly when the one-entry holding register is empty. A pair is accepted on a cycle where `smp_valid` and `smp_ready` are both high. Each frame consumes the oldest accepted pair at the `cell_tick` that emits its first half-cell.
- R9: If no pair is held when a frame begins, both subframes of that frame carry zero audio with the validity bit set to 1.
- R10: While `tx_en` is low, `spdif_out` is 0 from the next clock onward and `cell_tick` is ignored. When `tx_en` rises again, transmission restarts at frame 0 with the 8'hE8 preamble, starting from a low line.
- R11: After reset, `spdif_out` is 0 and `smp_ready` is 1.
- R12: `spdif_out` changes only on clock edges where `cell_tick` is high, except for the forced low level of R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable; low holds the line low and rewinds the block |
| cell_tick | input | 1 | Clock enable, one pulse per half bit cell |
| smp_valid | input | 1 | Sample pair offered |
| smp_ready | output | 1 | Holding register empty |
| smp_left | input | 24 | Left word: aux in bits 3:0, audio in bits 23:4 |
| smp_right | input | 24 | Right word, same layout |
| smp_invalid | input | 1 | Validity flag for the pair (1 = invalid) |
| chan_status | input | CS_BITS | Consumer channel-status word, bit f for frame f |
| spdif_out | output | 1 | Biphase-mark encoded serial line |

## Verification
The bench decodes the line itself. For every subframe it checks the preamble, the cell-boundary transitions, the parity, the user and validity bits and the channel-status bit. It also compares every half-cell level against an independent encoder model. Directed samples of all zeros, all ones and single set end bits catch a reversed bit order (audio would come out mirrored) and a parity taken over the wrong slots (odd ones counts). Random gaps between ticks catch a line that moves without a tick.

The feed is paused for two frames to force an underrun. A design that repeated the old sample, or left validity clear, would show the wrong audio or validity there. The channel-status word is changed mid-block and two full blocks are run, which exposes a design that applies the new word at once or that misplaces the wrap at frame 191. A disable in the middle of a subframe, followed by re-enable, checks that the line drops and that transmission restarts with the block-start preamble rather than resuming at the old frame.

// File: rtl/spdif_tx_pkg.sv
package spdif_tx_pkg;
  localparam int SMP_W      = 24;  // aux nibble + 20-bit audio
  localparam int SLOT_W     = 5;
  localparam int PRE_SLOTS  = 4;
  localparam int HALF_IDX_W = 3;
  localparam logic [7:0] PRE_BLOCK = 8'hE8;
  localparam logic [7:0] PRE_LEFT  = 8'hE2;
  localparam logic [7:0] PRE_RIGHT = 8'hE4;
  typedef struct packed {
    logic             invalid;
    logic [SMP_W-1:0] right;
    logic [SMP_W-1:0] left;
  } pair_t;
endpackage

// File: rtl/spdif_sample_buf.sv
module spdif_sample_buf
  import spdif_tx_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  in_valid,
  output logic  in_ready,
  input  pair_t in_pair,
  input  logic  take,
  output logic  full,
  output pair_t out_pair
);
  pair_t hold_q;
  logic  full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      hold_q <= '0;
    end else if (in_valid && !full_q) begin
      full_q <= 1'b1;
      hold_q <= in_pair;
    end else if (take) begin
      full_q <= 1'b0;
    end
  end

  assign in_ready = !full_q;
  assign full     = full_q;
  assign out_pair = hold_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (full_q && !take) |=> full_q); // R8
  AST_LOAD_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    $rose(full_q) |-> $past(in_valid)); // R8
endmodule

// File: rtl/spdif_slot_seq.sv
module spdif_slot_seq
  import spdif_tx_pkg::*;
#(
  parameter int BLOCK_FRAMES = 192,
  localparam int FW = $clog2(BLOCK_FRAMES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  output logic [SLOT_W-1:0] slot,
  output logic              half,
  output logic              sub,
  output logic [FW-1:0]     frame,
  output logic              first_frame,
  output logic              sf_start,
  output logic              frame_start,
  output logic              block_start
);
  localparam logic [FW-1:0]     LAST_FRAME = FW'(BLOCK_FRAMES - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT  = '1;

  logic [SLOT_W-1:0] slot_q;
  logic              half_q, sub_q;
  logic [FW-1:0]     frame_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      slot_q  <= '0;
      half_q  <= 1'b0;
      sub_q   <= 1'b0;
      frame_q <= '0;
    end else if (tick) begin
      half_q <= !half_q;
      if (half_q) begin
        slot_q <= slot_q + 1'b1;
        if (slot_q == LAST_SLOT) begin
          sub_q <= !sub_q;
          if (sub_q) frame_q <= (frame_q == LAST_FRAME) ? '0 : frame_q + 1'b1;
        end
      end
    end
  end

  assign slot        = slot_q;
  assign half        = half_q;
  assign sub         = sub_q;
  assign frame       = frame_q;
  assign first_frame = (frame_q == '0);
  assign sf_start    = (slot_q == '0) && !half_q;
  assign frame_start = sf_start && !sub_q;
  assign block_start = frame_start && first_frame;

  AST_FRAME_RANGE: assert property (@(posedge clk) disable iff (rst)
    frame_q <= LAST_FRAME); // R6
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
    (en && tick && half_q && slot_q == LAST_SLOT && sub_q && frame_q == LAST_FRAME)
      |=> (frame_q == '0)); // R6
endmodule

// File: rtl/spdif_subframe_fmt.sv
module spdif_subframe_fmt
  import spdif_tx_pkg::*;
#(
  parameter int CS_BITS = 40,
  parameter int FW      = 8,
  localparam int CW     = $clog2(CS_BITS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               adv,
  input  logic               frame_start,
  input  logic               block_start,
  input  logic               sub,
  input  logic [FW-1:0]      frame,
  input  logic               buf_full,
  input  pair_t              buf_pair,
  input  logic [CS_BITS-1:0] cs_in,
  output logic               take,
  output logic [31:0]        word
);
  pair_t              cur_q;
  logic [CS_BITS-1:0] cs_q;
  logic [SMP_W-1:0]   smp;
  logic               cs_bit;
  logic [26:0]        body;

  assign take = adv && frame_start && buf_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= '0;
      cs_q  <= '0;
    end else begin
      if (adv && frame_start) begin
        if (buf_full) cur_q <= buf_pair;
        else begin
          cur_q.left    <= '0;
          cur_q.right   <= '0;
          cur_q.invalid <= 1'b1;
        end
      end
      if (adv && block_start) cs_q <= cs_in;
    end
  end

  always_comb begin
    smp    = sub ? cur_q.right : cur_q.left;
    cs_bit = (frame < FW'(CS_BITS)) ? cs_q[frame[CW-1:0]] : 1'b0;
    body   = {cs_bit, 1'b0, cur_q.invalid, smp};
    word   = {^body, body, {PRE_SLOTS{1'b0}}};
  end

  AST_UNDERRUN_INVALID: assert property (@(posedge clk) disable iff (rst)
    (adv && frame_start && !buf_full)
      |=> (cur_q.invalid && cur_q.left == '0 && cur_q.right == '0)); // R9
endmodule

// File: rtl/spdif_bmc_enc.sv
module spdif_bmc_enc
  import spdif_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  input  logic [SLOT_W-1:0] slot,
  input  logic              half,
  input  logic              sub,
  input  logic              first_frame,
  input  logic              sf_start,
  input  logic [31:0]       word,
  output logic              line
);
  logic                  line_q, inv_q, inv, is_pre, pre_bit, nxt;
  logic [7:0]            pat;
  logic [HALF_IDX_W-1:0] pidx;

  always_comb begin
    pat     = sub ? PRE_RIGHT : (first_frame ? PRE_BLOCK : PRE_LEFT);
    pidx    = {slot[1:0], half};
    pre_bit = pat[3'd7 - pidx];
    inv     = sf_start ? line_q : inv_q;
    is_pre  = slot < SLOT_W'(PRE_SLOTS);
    if (is_pre)    nxt = pre_bit ^ inv;
    else if (half) nxt = line_q ^ word[slot];
    else           nxt = !line_q;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      line_q <= 1'b0;
      inv_q  <= 1'b0;
    end else if (tick) begin
      line_q <= nxt;
      if (sf_start) inv_q <= line_q;
    end
  end

  assign line = line_q;

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
    !en |=> !line_q); // R10
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> $stable(line_q)); // R12
  AST_CELL_EDGE: assert property (@(posedge clk) disable iff (rst)
    (en && tick && !is_pre && !half) |=> (line_q != $past(line_q))); // R4
endmodule

// File: rtl/spdif_bmc_tx.sv
module spdif_bmc_tx
  import spdif_tx_pkg::*;
#(
  parameter int BLOCK_FRAMES = 192,
  parameter int CS_BITS      = 40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tx_en,
  input  logic               cell_tick,
  input  logic               smp_valid,
  output logic               smp_ready,
  input  logic [SMP_W-1:0]   smp_left,
  input  logic [SMP_W-1:0]   smp_right,
  input  logic               smp_invalid,
  input  logic [CS_BITS-1:0] chan_status,
  output logic               spdif_out
);
  localparam int FW = $clog2(BLOCK_FRAMES);

  pair_t             in_pair, buf_pair;
  logic              buf_full, take, half, sub, first_frame;
  logic              sf_start, frame_start, block_start, adv;
  logic [SLOT_W-1:0] slot;
  logic [FW-1:0]     frame;
  logic [31:0]       word;

  assign in_pair = '{invalid: smp_invalid, right: smp_right, left: smp_left};
  assign adv     = tx_en && cell_tick;

  spdif_sample_buf u_buf (
    .clk(clk), .rst(rst), .in_valid(smp_valid), .in_ready(smp_ready),
    .in_pair(in_pair), .take(take), .full(buf_full), .out_pair(buf_pair)
  );

  spdif_slot_seq #(.BLOCK_FRAMES(BLOCK_FRAMES)) u_seq (
    .clk(clk), .rst(rst), .en(tx_en), .tick(cell_tick), .slot(slot),
    .half(half), .sub(sub), .frame(frame), .first_frame(first_frame),
    .sf_start(sf_start), .frame_start(frame_start), .block_start(block_start)
  );

  spdif_subframe_fmt #(.CS_BITS(CS_BITS), .FW(FW)) u_fmt (
    .clk(clk), .rst(rst), .adv(adv), .frame_start(frame_start),
    .block_start(block_start), .sub(sub), .frame(frame), .buf_full(buf_full),
    .buf_pair(buf_pair), .cs_in(chan_status), .take(take), .word(word)
  );

  spdif_bmc_enc u_enc (
    .clk(clk), .rst(rst), .en(tx_en), .tick(cell_tick), .slot(slot),
    .half(half), .sub(sub), .first_frame(first_frame), .sf_start(sf_start),
    .word(word), .line(spdif_out)
  );

  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (!spdif_out && smp_ready)); // R11
endmodule

// File: tb/spdif_bmc_tx_tb_top.sv
module spdif_bmc_tx_tb_top;
  localparam int NF = 192;
  localparam int NC = 40;

  logic clk = 0, rst = 1, tx_en = 0, cell_tick = 0;
  logic smp_valid = 0, smp_ready, smp_invalid = 0, spdif_out;
  logic [23:0] smp_left = 0, smp_right = 0;
  logic [NC-1:0] chan_status = 0;

  always #4 clk = ~clk;

  spdif_bmc_tx #(.BLOCK_FRAMES(NF), .CS_BITS(NC)) dut_i (
    .clk(clk), .rst(rst), .tx_en(tx_en), .cell_tick(cell_tick),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_left(smp_left),
    .smp_right(smp_right), .smp_invalid(smp_invalid),
    .chan_status(chan_status), .spdif_out(spdif_out));

  int checks = 0, failures = 0, hold_bad = 0, gf = 0, fm = 0, n = 0;
  bit feed_on = 0, done = 0, pl = 0, after_en = 0;
  logic [48:0] q[$];
  logic [NC-1:0] cs_lat = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // reference encoder: 64 half-cell levels, first emitted in bit 63
  function automatic logic [63:0] enc_sf(input logic [7:0] pat, input logic [27:0] d, input bit p);
    logic [63:0] r;
    logic lv;
    r = '0;
    lv = p;
    for (int h = 0; h < 8; h++) begin lv = pat[7-h] ^ p; r[63-h] = lv; end
    for (int b = 0; b < 28; b++) begin
      lv = ~lv; r[63-(8+2*b)] = lv;
      lv = lv ^ d[b]; r[63-(9+2*b)] = lv;
    end
    return r;
  endfunction

  function automatic logic [23:0] gen_word(input int k, input bit right);
    if (k == 0) return 24'h000000;
    if (k == 1) return 24'hFFFFFF;
    if (k == 2) return right ? 24'h000001 : 24'h800001;
    return 24'($urandom);
  endfunction

  // producer: offers pairs, logs each accepted pair in order
  initial begin
    bit fire, need_new;
    fire = 0; need_new = 1;
    @(negedge clk);
    wait (!rst);
    forever begin
      @(negedge clk);
      if (fire) begin need_new = 1; fire = 0; end
      if (need_new && feed_on) begin
        smp_left = gen_word(n, 0); smp_right = gen_word(n, 1);
        smp_invalid = (n == 1) ? 1'b1 : (n < 3 ? 1'b0 : (($urandom % 4) == 0));
        smp_valid = 1; need_new = 0; n++;
      end else if (!feed_on && smp_valid && !smp_ready) begin
        smp_valid = 0; need_new = 1;
      end
      if (smp_valid && smp_ready) begin
        q.push_back({smp_invalid, smp_right, smp_left});
        fire = 1;
      end
    end
  end

  task automatic step_half(output bit v);
    int g;
    @(negedge clk); cell_tick = 1;
    @(negedge clk); cell_tick = 0;
    v = spdif_out;
    g = $urandom_range(0, 1);
    repeat (g) begin @(negedge clk); if (spdif_out != v) hold_bad++; end
  endtask

  task automatic hooks();
    if (gf == 5) feed_on = 0;
    if (gf == 8) feed_on = 1;
    if (gf == 100) chan_status = {8'($urandom), 32'($urandom)};
  endtask

  task automatic run_frame();
    logic [48:0] s;
    bit und, v;
    logic [7:0] pat, pa;
    logic [23:0] smp, got;
    logic [27:0] d, bits;
    logic [63:0] exp, act;
    logic csb;
    int nob;
    if (fm == 0) cs_lat = chan_status;
    if (q.size() > 0) begin s = q.pop_front(); und = 0; end
    else begin s = {1'b1, 48'h0}; und = 1; end
    for (int sb = 0; sb < 2; sb++) begin
      if (sb == 1) hooks();
      pat = (sb == 1) ? 8'hE4 : (fm == 0 ? 8'hE8 : 8'hE2);
      smp = (sb == 1) ? s[47:24] : s[23:0];
      csb = (fm < NC) ? cs_lat[fm] : 1'b0;
      d[25:0] = {1'b0, s[48], smp};
      d[26] = csb;
      d[27] = ^d[26:0];
      exp = enc_sf(pat, d, pl);
      hold_bad = 0;
      for (int h = 0; h < 64; h++) begin step_half(v); act[63-h] = v; end
      pa = act[63:56];
      chk(pa == (pat ^ {8{pl}}), "R5 preamble", pa, pat ^ {8{pl}});
      if (after_en && sb == 0) chk(pa == 8'hE8, "R10 restart preamble", pa, 8'hE8);
      nob = 0;
      for (int b = 0; b < 28; b++) begin
        if (act[63-(8+2*b)] == act[63-(7+2*b)]) nob++;
        bits[b] = act[63-(8+2*b)] ^ act[63-(9+2*b)];
      end
      chk(nob == 0, "R4 cell boundary", nob, 0);
      got = bits[23:0];
      chk(got == smp, und ? "R9 underrun audio" : "R1 R8 audio", got, smp);
      chk(bits[24] == s[48], und ? "R9 underrun validity" : "R2 validity", bits[24], s[48]);
      chk(bits[25] == 1'b0, "R2 user bit", bits[25], 0);
      chk(bits[26] == csb, "R6 R7 channel status", bits[26], csb);
      chk((^bits) == 1'b0, "R3 parity", bits, 0);
      chk(act == exp, "R4 levels", act, exp);
      chk(hold_bad == 0, "R12 hold without tick", hold_bad, 0);
      pl = exp[0];
      after_en = 0;
    end
    fm = (fm == NF - 1) ? 0 : fm + 1;
    gf++;
  endtask

  initial begin
    bit v;
    int zeros;
    void'($urandom(32'h5EED1234));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(spdif_out == 0, "R11 reset line", spdif_out, 0);
    chk(smp_ready == 1, "R11 reset ready", smp_ready, 1);
    feed_on = 1;
    repeat (6) @(negedge clk);
    chk(smp_ready == 0, "R8 ready low when held", smp_ready, 0);
    chan_status = {1'b1, 31'($urandom), 7'h01, 1'b1};
    tx_en = 1;
    for (int f = 0; f < 2 * NF + 2; f++) run_frame();
    // disable mid-subframe
    if (q.size() > 0) void'(q.pop_front());
    for (int h = 0; h < 37; h++) step_half(v);
    @(negedge clk); tx_en = 0;
    @(negedge clk);
    chk(spdif_out == 0, "R10 line low when off", spdif_out, 0);
    zeros = 0;
    for (int h = 0; h < 6; h++) begin step_half(v); if (v) zeros++; end
    chk(zeros == 0, "R10 ticks ignored when off", zeros, 0);
    tx_en = 1; fm = 0; pl = 0; after_en = 1;
    for (int f = 0; f < 3; f++) run_frame();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule